// File: doc/BRIEF.md
# Interrupt Status and Alert Line Manager

This block gathers fault causes from a thermal and fan supervisor into two 8-bit interrupt status banks and drives one active-low alert line, shaped for an open-drain pad. The causes are temperature over-limit on four channels, diode faults on three channels, a fan stall, a failed spin-up, a low power-good supply, a thermal trip, and a hardware shutdown. Every status bit is sticky. When a status bank is read, its bits are cleared only where their cause has gone away. A bit whose cause is still active stays set and keeps driving the alert line.

The serial bus engine sits outside this block. It presents a one-cycle read strobe with a register address and receives the bank contents one cycle later. When it recognises an alert-response query, it pulses a strobe into this block. The block acknowledges that query while the alert line is low, but the query alone does not release the line. Per-source mask inputs stop individual causes from setting their status bits.

Top module: `intr_alert_mgr`

## Requirements
- R1: While reset is high, and in the first cycle after it, the status banks are zero, `alert_n_o` is 1, `rd_data_o` is 0 and `ara_ack_o` is 0.
- R2: An unmasked cause that is active in a cycle sets its status bit at the next clock edge. The bit then stays set after the cause goes away, until a clearing read of its bank.
- R3: A read strobe with address 0x23 returns bank A, and a read strobe with address 0x24 returns bank B, on `rd_data_o` in the following cycle. Any other address returns 0 and clears nothing.
- R4: A read of a bank clears each of that bank's bits whose cause is inactive in the read cycle. A bit whose cause is active in the read cycle stays set.
- R5: If a cause first appears in the same cycle as a clearing read of its bank, its bit is set after that edge, even though the read data returns the earlier value.
- R6: Bank A bits 0-3 are temperature over-limit (`cond_i[3:0]`) and bits 4-6 are diode faults (`cond_i[6:4]`); bit 7 is the reset-pin indication (`cond_i[7]`) and does not drive the alert line. Bank B bit 0 is fan stall (`cond_i[8]`) and bit 1 is spin failure (`cond_i[9]`); these two drive the alert line. Bank B bits 5 and 6 (hardware shutdown `cond_i[13]`, thermal trip `cond_i[14]`) do not drive it. `alert_n_o` is 0 exactly when an alert-capable bit is set.
- R7: Bank B bit 7 is set while `pwr_good_i` is 0, and it does not drive the alert line.
- R8: When `src_mask_i[k]` is 1, status bit k cannot be set, where bank A is bits 7:0 and bank B is bits 15:8. A bit that is already set is unaffected by the mask until it is read.
- R9: An `ara_hit_i` pulse while `alert_n_o` is 0 gives `ara_ack_o` = 1 in the next cycle, and the alert line stays low. A pulse while `alert_n_o` is 1 gives no acknowledge.
- R10: Bank B bits 2-4 (`cond_i[12:10]`) are not implemented and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 15 | Fault causes, level sensitive, mapped to status bits 14:0 |
| pwr_good_i | input | 1 | Supply power-good level, low means fault |
| src_mask_i | input | 16 | Per status bit set-inhibit |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe |
| ara_hit_i | input | 1 | Alert-response query recognised |
| ara_ack_o | output | 1 | Acknowledge of the query |
| alert_n_o | output | 1 | Active-low alert line |

## Verification
A clearing read and a newly arriving cause can land on the same clock edge. In that case the set must win, while the read data still shows the earlier contents. The bench raises a fresh cause exactly in the read-strobe cycle and then reads the bank again. It expects the bit to be missing from the first read and present in the second. An alert-response strobe is also placed alongside a set alert. In that case the acknowledge must appear and the alert line must stay low, and a reference model judges both outputs on every clock.

// File: rtl/ia_pkg.sv
package ia_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_BANKS = 2;
    localparam int SRC_W     = REG_W * NUM_BANKS;

    typedef logic [REG_W-1:0] stat_t;

    // Implemented bits per bank.
    function automatic stat_t bank_impl(input int b);
        return (b == 0) ? 8'hFF : 8'hE3;
    endfunction

    // Bits that may pull the alert line low.
    function automatic stat_t bank_cap(input int b);
        return (b == 0) ? 8'h7F : 8'h03;
    endfunction

    typedef struct packed {
        logic               valid;
        logic [NUM_BANKS-1:0] hit;
    } rd_req_t;
endpackage

// File: rtl/ia_addr_decode.sv
module ia_addr_decode
    import ia_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_ADDRS = '0
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_req_t           req
);
    logic [NUM_BANKS-1:0] hit_w;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        assign hit_w[b] = rd_en && (rd_addr == BANK_ADDRS[b*ADDR_W +: ADDR_W]);
    end

    assign req.valid = |hit_w;
    assign req.hit   = hit_w;
endmodule

// File: rtl/ia_status_bank.sv
module ia_status_bank
    import ia_pkg::*;
#(
    parameter stat_t IMPL = '1,
    parameter stat_t CAP  = '1
) (
    input  logic  clk,
    input  logic  rst,
    input  stat_t cause_raw,
    input  stat_t mask,
    input  logic  clr,
    output stat_t stat,
    output logic  alert_req
);
    stat_t cause;
    stat_t stat_q;

    assign cause = cause_raw & ~mask & IMPL;

    // Set beats clear: a live cause is re-applied on the clearing edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (cause | (clr ? '0 : stat_q)) & IMPL;
        end
    end

    assign stat      = stat_q;
    assign alert_req = |(stat_q & CAP);
endmodule

// File: rtl/ia_alert_ara.sv
module ia_alert_ara
    import ia_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] alert_req,
    input  logic                 ara_hit,
    output logic                 alert_n,
    output logic                 ara_ack
);
    logic any_alert;

    assign any_alert = |alert_req;
    assign alert_n   = ~any_alert;

    always_ff @(posedge clk) begin
        if (rst) begin
            ara_ack <= 1'b0;
        end else begin
            ara_ack <= ara_hit && any_alert;
        end
    end
endmodule

// File: rtl/intr_alert_mgr.sv
module intr_alert_mgr
    import ia_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  STAT_A_ADDR = 8'h23,
    parameter logic [7:0]  STAT_B_ADDR = 8'h24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [14:0]       cond_i,
    input  logic              pwr_good_i,
    input  logic [15:0]       src_mask_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    input  logic              ara_hit_i,
    output logic              ara_ack_o,
    output logic              alert_n_o
);
    localparam logic [NUM_BANKS*ADDR_W-1:0] BANK_ADDRS =
        {STAT_B_ADDR[ADDR_W-1:0], STAT_A_ADDR[ADDR_W-1:0]};

    logic [SRC_W-1:0]     raw_src;
    rd_req_t              req;
    stat_t                stat_w [NUM_BANKS];
    logic [NUM_BANKS-1:0] alert_req;
    stat_t                stat_a;
    stat_t                stat_b;
    stat_t                rd_q;

    // Power-good fault is the inverted supply level.
    assign raw_src = {~pwr_good_i, cond_i};

    ia_addr_decode #(
        .ADDR_W     (ADDR_W),
        .BANK_ADDRS (BANK_ADDRS)
    ) u_dec (
        .rd_en   (rd_en_i),
        .rd_addr (rd_addr_i),
        .req     (req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ia_status_bank #(
            .IMPL (bank_impl(b)),
            .CAP  (bank_cap(b))
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .cause_raw (raw_src[b*REG_W +: REG_W]),
            .mask      (src_mask_i[b*REG_W +: REG_W]),
            .clr       (req.hit[b]),
            .stat      (stat_w[b]),
            .alert_req (alert_req[b])
        );
    end

    assign stat_a = stat_w[0];
    assign stat_b = stat_w[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (req.hit[0]) begin
            rd_q <= stat_a;
        end else if (req.hit[1]) begin
            rd_q <= stat_b;
        end else begin
            rd_q <= '0;
        end
    end

    assign rd_data_o = rd_q;

    ia_alert_ara u_alert (
        .clk       (clk),
        .rst       (rst),
        .alert_req (alert_req),
        .ara_hit   (ara_hit_i),
        .alert_n   (alert_n_o),
        .ara_ack   (ara_ack_o)
    );
endmodule

// File: rtl/intr_alert_chk.sv
module intr_alert_chk #(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] STAT_A_ADDR = 8'h23
) (
    input logic              clk,
    input logic              rst,
    input logic [14:0]       cond_i,
    input logic              pwr_good_i,
    input logic [15:0]       src_mask_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic              ara_hit_i,
    input logic              ara_ack_o,
    input logic              alert_n_o,
    input logic [7:0]        stat_a,
    input logic [7:0]        stat_b
);
    logic rd_a;
    assign rd_a = rd_en_i && (rd_addr_i == STAT_A_ADDR[ADDR_W-1:0]);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (alert_n_o && !ara_ack_o && stat_a == 8'h00));

    // R2
    sticky_a_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_a |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i[0] && !src_mask_i[0]) |=> stat_a[0]);

    // R7
    pwr_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_good_i && !src_mask_i[15]) |=> stat_b[7]);

    // R9
    ara_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ara_hit_i && !alert_n_o && !rd_en_i) |=> (ara_ack_o && !alert_n_o));

    // R10
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat_b[4:2] == 3'b000);
endmodule

bind intr_alert_mgr intr_alert_chk #(
    .ADDR_W      (ADDR_W),
    .STAT_A_ADDR (STAT_A_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cond_i     (cond_i),
    .pwr_good_i (pwr_good_i),
    .src_mask_i (src_mask_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .ara_hit_i  (ara_hit_i),
    .ara_ack_o  (ara_ack_o),
    .alert_n_o  (alert_n_o),
    .stat_a     (stat_a),
    .stat_b     (stat_b)
);

// File: tb/intr_alert_mgr_tb.sv
`timescale 1ns/1ps
module intr_alert_mgr_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] cond = '0;
    logic        pg = 1'b1;
    logic [15:0] mask = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        ara = 1'b0;
    logic        ack;
    logic        alert_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    intr_alert_mgr u_dut (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (cond),
        .pwr_good_i (pg),
        .src_mask_i (mask),
        .rd_en_i    (rd_en),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .ara_hit_i  (ara),
        .ara_ack_o  (ack),
        .alert_n_o  (alert_n)
    );

    // Behavioural reference model
    logic [7:0] m_a = '0, m_b = '0, m_rd = '0;
    logic       m_ack = 1'b0;

    function automatic bit cause_of(input int k);
        if (mask[k]) return 0;
        if (k < 8) return cond[k];
        if (k == 8 || k == 9 || k == 13 || k == 14) return cond[k];
        if (k == 15) return !pg;
        return 0;
    endfunction

    function automatic bit m_alert();
        for (int i = 0; i < 7; i++) if (m_a[i]) return 1;
        return m_b[0] || m_b[1];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_a <= '0; m_b <= '0; m_rd <= '0; m_ack <= 0;
        end else begin
            logic [7:0] na, nb;
            bit clr_a, clr_b;
            clr_a = rd_en && rd_addr == 8'h23;
            clr_b = rd_en && rd_addr == 8'h24;
            for (int i = 0; i < 8; i++) begin
                na[i] = cause_of(i)     ? 1'b1 : (clr_a ? 1'b0 : m_a[i]);
                nb[i] = cause_of(i + 8) ? 1'b1 : (clr_b ? 1'b0 : m_b[i]);
            end
            m_rd  <= clr_a ? m_a : (clr_b ? m_b : 8'h00);
            m_ack <= ara && m_alert();
            m_a <= na;
            m_b <= nb;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R3 model rd_data", int'(rd_data), int'(m_rd));
            check("R6 model alert_n", int'(alert_n), int'(!m_alert()));
            check("R9 model ara_ack", int'(ack), int'(m_ack));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        cond = '0; pg = 1; mask = '0; rd_en = 0; ara = 0;
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        rd_en = 1; rd_addr = a;
        tick();
        rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        cmp_on = 1;
        tick();
        // R1
        check("R1 alert_n", alert_n, 1);
        check("R1 rd_data", rd_data, 0);
        check("R1 ara_ack", ack, 0);

        // R2, R3, R4
        cond = 15'h0002; tick();
        check("R2 alert set", alert_n, 0);
        cond = '0; tick(); tick();
        check("R2 sticky", alert_n, 0);
        rd(8'h23);
        check("R3 read A", rd_data, 8'h02);
        check("R4 cleared", alert_n, 1);

        cond = 15'h0010; tick();
        rd(8'h23);
        check("R4 live read", rd_data, 8'h10);
        tick();
        check("R4 live stays", alert_n, 0);
        rd(8'h23);
        check("R4 still set", rd_data, 8'h10);

        // R6 reset-pin bit
        do_reset();
        cond = 15'h0080; tick(); tick();
        check("R6 A7 no alert", alert_n, 1);
        rd(8'h23);
        check("R6 A7 read", rd_data, 8'h80);

        // R7, R6 bank B excluded bits
        do_reset();
        pg = 0; cond = 15'h6000; tick(); tick();
        check("R6 B5-7 no alert", alert_n, 1);
        rd(8'h24);
        check("R7 read B", rd_data, 8'hE0);

        // R10
        do_reset();
        cond = 15'h1C00; tick();
        rd(8'h24);
        check("R10 unimpl", rd_data, 8'h00);
        check("R10 no alert", alert_n, 1);

        // R5
        do_reset();
        rd_en = 1; rd_addr = 8'h23; cond = 15'h0001;
        tick();
        check("R5 old data", rd_data, 8'h00);
        cond = '0;
        tick();
        check("R5 bit kept", rd_data, 8'h01);
        rd_en = 0;
        tick();
        check("R5 then cleared", rd_data, 8'h00);

        // R8
        do_reset();
        mask = 16'h0100; cond = 15'h0100; tick(); tick();
        check("R8 masked alert", alert_n, 1);
        rd(8'h24);
        check("R8 masked read", rd_data, 8'h00);
        mask = '0; tick();
        cond = '0; mask = 16'h0100; tick();
        rd(8'h24);
        check("R8 set survives mask", rd_data, 8'h01);

        // R9
        do_reset();
        cond = 15'h0001; tick();
        cond = '0; ara = 1; tick();
        ara = 0;
        check("R9 ack", ack, 1);
        check("R9 alert held", alert_n, 0);
        tick();
        check("R9 ack pulse", ack, 0);
        check("R9 alert still", alert_n, 0);
        rd(8'h23);
        ara = 1; tick(); ara = 0;
        check("R9 no ack idle", ack, 0);

        // R3 unknown address
        do_reset();
        cond = 15'h0002; tick(); cond = '0;
        rd(8'h30);
        check("R3 unknown data", rd_data, 8'h00);
        tick();
        check("R3 unknown no clear", alert_n, 0);
        rd(8'h24);
        check("R3 read B empty", rd_data, 8'h00);
        check("R3 A kept", alert_n, 0);

        tick(); tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule